// File: doc/BRIEF.md
# Processor Flags Register

This block holds the processor's 32-bit status and control word. The arithmetic status flags, the string direction flag and the system flags each sit at a fixed bit position. Every bit that has no defined meaning is tied to a constant value and cannot be changed through any path.

The register can be changed in four ways:
- a full 32-bit load;
- a load of the low half only, which leaves the upper half as it was;
- a dedicated command that sets, clears or inverts the carry flag;
- an update from the ALU, in which a per-flag mask picks which status flags take new values.

When several of these arrive in the same cycle, a fixed priority picks exactly one of them. The registered word is driven out every cycle.

Reset is asserted asynchronously and its release is synchronised to the clock inside the block.

Top module: `flagword_reg`

## Requirements
- R1: While reset is active, and after it is released with no update applied, `flags_q` reads 0x00000002.
- R2: On every update path, bit 1 reads 1 and bits 3, 5, 15 and 31:18 read 0, whatever data is supplied.
- R3: A full load (`wr_full_en`=1) makes `flags_q` equal to `wr_data` masked with 0x00037FD5 and ORed with 0x00000002, one cycle later.
  - The masked-in bits are: bit 0 carry, bit 2 parity, bit 4 auxiliary carry, bit 6 zero, bit 7 sign, bit 8 trap, bit 9 interrupt enable, bit 10 direction, bit 11 overflow, bits 13:12 I/O privilege, bit 14 nested task, bit 16 resume, bit 17 virtual mode.
- R4: A low-half load (`wr_low_en`=1) writes `wr_data[15:0]` into bits 15:0 under the same fixing rule. Bits 31:16 are left unchanged.
- R5: The carry command `cf_cmd` is encoded as 01 = set bit 0, 10 = clear bit 0, 11 = invert bit 0, 00 = none. Only bit 0 changes.
- R6: An ALU update (`alu_en`=1) writes `alu_flags[i]` into a flag only where `alu_mask[i]`=1. Every other bit holds.
  - Index i maps to flags as: 0 carry (bit 0), 1 parity (bit 2), 2 auxiliary carry (bit 4), 3 zero (bit 6), 4 sign (bit 7), 5 overflow (bit 11).
- R7: When several sources are active in one cycle, only the highest-priority one takes effect. The order, from highest, is: full load, low-half load, carry command, ALU update.
- R8: With no source active, `flags_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_full_en | input | 1 | Load all 32 bits from `wr_data` |
| wr_low_en | input | 1 | Load bits 15:0 from `wr_data` |
| wr_data | input | 32 | Load data |
| cf_cmd | input | 2 | Carry command: 00 none, 01 set, 10 clear, 11 invert |
| alu_en | input | 1 | Apply ALU status update |
| alu_mask | input | 6 | Per-flag update select |
| alu_flags | input | 6 | New status flag values |
| flags_q | output | 32 | Current register value |

## Verification
The carry command and the ALU update are the pair most likely to meet in one cycle, because both can target bit 0. A full load and a low-half load can also coincide.

The bench sweeps all 32 combinations of the four sources, and every carry-command encoding, across several register states. Each result is compared with a bench model that applies only the winning source. A cycle where the carry command should win but the ALU mask also selects carry shows directly whether the lower-priority update leaked through.

// File: rtl/flagword_pkg.sv
package flagword_pkg;
  localparam int unsigned FW_WIDTH  = 32;
  localparam int unsigned FW_NSTAT  = 6;
  localparam int unsigned FW_HALF   = FW_WIDTH / 2;
  localparam logic [FW_WIDTH-1:0] FW_LIVE_MASK = 32'h0003_7FD5;
  localparam logic [FW_WIDTH-1:0] FW_ONE_MASK  = 32'h0000_0002;
  localparam logic [FW_WIDTH-1:0] FW_RESET     = FW_ONE_MASK;

  typedef enum logic [1:0] {
    CF_NONE = 2'b00,
    CF_SET  = 2'b01,
    CF_CLR  = 2'b10,
    CF_INV  = 2'b11
  } cf_cmd_e;

  // Bit position of status flag index i (carry, parity, aux, zero, sign, overflow).
  function automatic int unsigned stat_pos(input int unsigned i);
    case (i)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return 6;
      4: return 7;
      default: return 11;
    endcase
  endfunction

  function automatic logic [FW_WIDTH-1:0] fix_reserved(input logic [FW_WIDTH-1:0] v);
    return (v & FW_LIVE_MASK) | FW_ONE_MASK;
  endfunction
endpackage

// File: rtl/flagword_carry_op.sv
module flagword_carry_op
  import flagword_pkg::*;
(
  input  logic [FW_WIDTH-1:0] cur,
  input  logic [1:0]          cmd,
  output logic [FW_WIDTH-1:0] res
);
  always_comb begin
    res = cur;
    case (cf_cmd_e'(cmd))
      CF_SET:  res[0] = 1'b1;
      CF_CLR:  res[0] = 1'b0;
      CF_INV:  res[0] = ~cur[0];
      default: res[0] = cur[0];
    endcase
  end
endmodule

// File: rtl/flagword_alu_merge.sv
module flagword_alu_merge
  import flagword_pkg::*;
(
  input  logic [FW_WIDTH-1:0] cur,
  input  logic [FW_NSTAT-1:0] mask,
  input  logic [FW_NSTAT-1:0] flags,
  output logic [FW_WIDTH-1:0] res
);
  logic [FW_WIDTH-1:0] sel_bits;
  logic [FW_WIDTH-1:0] new_bits;

  for (genvar g = 0; g < FW_WIDTH; g++) begin : g_bit
    logic hit;
    logic val;
    always_comb begin
      hit = 1'b0;
      val = 1'b0;
      for (int i = 0; i < int'(FW_NSTAT); i++) begin
        if (stat_pos(i) == g) begin
          hit = mask[i];
          val = flags[i];
        end
      end
    end
    assign sel_bits[g] = hit;
    assign new_bits[g] = val;
  end

  assign res = (cur & ~sel_bits) | (new_bits & sel_bits);
endmodule

// File: rtl/flagword_reg.sv
module flagword_reg
  import flagword_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_full_en,
  input  logic                wr_low_en,
  input  logic [31:0]         wr_data,
  input  logic [1:0]          cf_cmd,
  input  logic                alu_en,
  input  logic [5:0]          alu_mask,
  input  logic [5:0]          alu_flags,
  output logic [31:0]         flags_q
);
  logic [1:0]          rst_pipe;
  logic                rst_sync_n;
  logic [FW_WIDTH-1:0] carry_res;
  logic [FW_WIDTH-1:0] alu_res;
  logic [FW_WIDTH-1:0] flags_nxt;
  logic                flags_en;

  // Reset: asserts asynchronously, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  flagword_carry_op u_carry (
    .cur (flags_q),
    .cmd (cf_cmd),
    .res (carry_res)
  );

  flagword_alu_merge u_alu (
    .cur   (flags_q),
    .mask  (alu_mask),
    .flags (alu_flags),
    .res   (alu_res)
  );

  // Next state, with priority: full load, low load, carry command, ALU update.
  always_comb begin
    flags_nxt = flags_q;
    flags_en  = 1'b1;
    if (wr_full_en)
      flags_nxt = fix_reserved(wr_data);
    else if (wr_low_en)
      flags_nxt = fix_reserved({flags_q[FW_WIDTH-1:FW_HALF], wr_data[FW_HALF-1:0]});
    else if (cf_cmd != CF_NONE)
      flags_nxt = carry_res;
    else if (alu_en)
      flags_nxt = alu_res;
    else
      flags_en  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   flags_q <= FW_RESET;
    else if (flags_en) flags_q <= flags_nxt;
  end

  a_r2_reserved_fixed: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flags_q & ~FW_LIVE_MASK) == FW_ONE_MASK);

  a_r3_full_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_full_en |=> flags_q == (($past(wr_data) & FW_LIVE_MASK) | FW_ONE_MASK));

  a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_low_en && !wr_full_en) |=> flags_q[31:16] == $past(flags_q[31:16]));

  a_r5_carry_invert: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_full_en && !wr_low_en && cf_cmd == 2'b11) |=>
      (flags_q[0] != $past(flags_q[0])) && (flags_q[31:1] == $past(flags_q[31:1])));

  a_r6_empty_mask: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_full_en && !wr_low_en && cf_cmd == 2'b00 && alu_en && alu_mask == 6'd0)
      |=> $stable(flags_q));

  a_r7_carry_over_alu: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_full_en && !wr_low_en && cf_cmd == 2'b01 && alu_en) |=> flags_q[0]);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_full_en && !wr_low_en && cf_cmd == 2'b00 && !alu_en) |=> $stable(flags_q));
endmodule

// File: tb/sim_flagword_reg.sv
module sim_flagword_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_full_en, wr_low_en, alu_en;
  logic [31:0] wr_data;
  logic [1:0]  cf_cmd;
  logic [5:0]  alu_mask, alu_flags;
  logic [31:0] flags_q;

  int checks = 0;
  int fails = 0;
  logic [31:0] model_q;
  logic [31:0] lfsr = 32'hACE1_2345;
  bit done = 0;

  always #4 clk = ~clk;

  flagword_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_full_en(wr_full_en), .wr_low_en(wr_low_en),
    .wr_data(wr_data), .cf_cmd(cf_cmd), .alu_en(alu_en), .alu_mask(alu_mask),
    .alu_flags(alu_flags), .flags_q(flags_q));

  function automatic logic [31:0] model_next(
    input logic [31:0] cur, input logic f, input logic l, input logic [31:0] d,
    input logic [1:0] c, input logic a, input logic [5:0] m, input logic [5:0] fl);
    logic [31:0] r;
    int pos[6] = '{0, 2, 4, 6, 7, 11};
    r = cur;
    if (f)           r = (d & 32'h0003_7FD5) | 32'h2;
    else if (l)      r = ({cur[31:16], d[15:0]} & 32'h0003_7FD5) | 32'h2;
    else if (c == 1) r[0] = 1'b1;
    else if (c == 2) r[0] = 1'b0;
    else if (c == 3) r[0] = ~cur[0];
    else if (a) begin
      for (int i = 0; i < 6; i++) if (m[i]) r[pos[i]] = fl[i];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (flags_q !== exp) begin
      fails++;
      $display("FAIL %s: flags_q=%08h expected=%08h", req, flags_q, exp);
    end
  endtask

  task automatic next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  // Called at a falling edge; applies one cycle of stimulus and checks at the next falling edge.
  task automatic step(input string req, input logic f, input logic l, input logic [31:0] d,
                      input logic [1:0] c, input logic a, input logic [5:0] m, input logic [5:0] fl);
    wr_full_en = f; wr_low_en = l; wr_data = d; cf_cmd = c;
    alu_en = a; alu_mask = m; alu_flags = fl;
    model_q = model_next(model_q, f, l, d, c, a, m, fl);
    @(posedge clk);
    @(negedge clk);
    check(req, model_q);
    if ((flags_q & ~32'h0003_7FD5) !== 32'h2) begin
      checks++; fails++;
      $display("FAIL R2: flags_q=%08h fixed bits expected %08h",
               flags_q & ~32'h0003_7FD5, 32'h2);
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: flags_q=%08h expected=completion", flags_q);
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_full_en = 0; wr_low_en = 0; wr_data = '0;
    cf_cmd = 0; alu_en = 0; alu_mask = 0; alu_flags = 0;
    model_q = 32'h2;
    repeat (3) @(negedge clk);
    check("R1 in reset", 32'h2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 32'h2);

    // R3 full loads: all ones, zero, walking ones, pseudo-random.
    step("R3 ones", 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step("R8 idle", 0, 0, 32'h0, 0, 0, 0, 0);
    step("R3 zero", 1, 0, 32'h0, 0, 0, 0, 0);
    for (int b = 0; b < 32; b++) step("R3 walk", 1, 0, 32'h1 << b, 0, 0, 0, 0);
    for (int k = 0; k < 40; k++) begin
      next_rand();
      step("R3 rand", 1, 0, lfsr, 0, 0, 0, 0);
      step("R8 idle", 0, 0, ~lfsr, 0, 0, 6'h3F, 6'h15);
    end

    // R4 low-half loads over varied upper halves.
    for (int k = 0; k < 40; k++) begin
      next_rand();
      step("R4 setup", 1, 0, lfsr, 0, 0, 0, 0);
      next_rand();
      step("R4 low load", 0, 1, lfsr, 0, 0, 0, 0);
    end

    // R5 every carry encoding from both carry states.
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 4; c++) begin
        step("R5 setup", 1, 0, 32'h0003_7FD4 | 32'(s), 0, 0, 0, 0);
        step("R5 carry", 0, 0, 32'h0, 2'(c), 0, 0, 0);
        step("R5 carry again", 0, 0, 32'hFFFF_FFFF, 2'(c), 0, 0, 0);
      end

    // R6 exhaustive mask by value sweep.
    for (int m = 0; m < 64; m++)
      for (int v = 0; v < 64; v++) begin
        if (v % 16 == 0) begin
          next_rand();
          step("R6 setup", 1, 0, lfsr, 0, 0, 0, 0);
        end
        step("R6 alu", 0, 0, 32'h0, 0, 1, 6'(m), 6'(v));
      end

    // R7 every combination of the four sources and carry encodings.
    for (int rep = 0; rep < 8; rep++)
      for (int e = 0; e < 32; e++) begin
        next_rand();
        step("R7 setup", 1, 0, ~lfsr, 0, 0, 0, 0);
        next_rand();
        step("R7 collide", e[0], e[1], lfsr, 2'(e[3:2]), e[4], 6'h3F, ~lfsr[5:0]);
      end

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end
endmodule